// File: doc/BRIEF.md
# Fixed-Pattern Offset Removal and Gamma Mapping Pipeline

This block cleans up raw image-sensor samples while they stream in at sensor rate. Every linear 10-bit sample is paired with an offset word for the same pixel position. The offset words come from external frame memory in pixel order, through a valid/ready stream. The block removes the offset to cancel fixed-pattern noise. Results that would go negative are floored at zero. The corrected value then indexes an on-chip 1024-entry table, which returns an 8-bit display-gamma value. The 8-bit pixels leave on a valid-qualified write stream toward memory, and start-of-frame and end-of-line markers travel alongside them.

A runtime control sends the raw sample straight to the table, skipping the correction. The offset stream is still consumed in this mode, so it stays aligned to pixel positions. Software fills the table through a separate write port while no pixels flow. A synchronous reset empties the pipeline and leaves the table contents unchanged.

Top module: `fpn_gamma_pipe`

## Requirements
- R1: With `corr_en`=1 and `pix_data` >= `ofs_data`, an accepted pixel produces `out_data` = table[`pix_data` - `ofs_data`].
- R2: With `corr_en`=1 and `pix_data` < `ofs_data`, the corrected index is 0 and does not wrap, so `out_data` = table[0].
- R3: With `corr_en`=0, an accepted pixel produces `out_data` = table[`pix_data`]. The offset word is still consumed.
- R4: A pixel is accepted only in a cycle where `pix_valid`=1, `ofs_valid`=1 and `lut_we`=0. `ofs_ready` is 1 exactly when `pix_valid`=1 and `lut_we`=0.
- R5: When `pix_valid`=1, `ofs_valid`=0 and `lut_we`=0, `underrun` is 1 in the next cycle and no output pixel results. In every other case `underrun` is 0 in the next cycle.
- R6: `out_valid` is 1 in cycle n+3 exactly when a pixel was accepted in cycle n. The latency is fixed at three cycles and unaffected by gaps in the input.
- R7: `out_sof` and `out_eol` carry the `pix_sof` and `pix_eol` values of the accepted pixel whose data appears on `out_data`.
- R8: When `lut_we`=1, table entry `lut_addr` takes `lut_wdata` at the clock edge. In that cycle any presented pixel is ignored: there is no output and no underrun.
- R9: A cycle with `rst`=1 drives `out_valid` and `underrun` to 0 in the following cycle and discards pixels in flight. Table contents written before the reset still map pixels afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| corr_en | input | 1 | 1 = subtract offset, 0 = raw sample to table |
| pix_valid | input | 1 | Sensor sample present |
| pix_data | input | 10 | Linear sensor sample |
| pix_sof | input | 1 | Sample is first of a frame |
| pix_eol | input | 1 | Sample is last of a line |
| ofs_valid | input | 1 | Offset word present |
| ofs_data | input | 10 | Offset for the current pixel position |
| ofs_ready | output | 1 | Offset word consumed when also valid |
| lut_we | input | 1 | Table write strobe |
| lut_addr | input | 10 | Table write address |
| lut_wdata | input | 8 | Table write data |
| out_valid | output | 1 | Processed pixel present |
| out_data | output | 8 | Gamma-mapped pixel |
| out_sof | output | 1 | Delayed start-of-frame marker |
| out_eol | output | 1 | Delayed end-of-line marker |
| underrun | output | 1 | Pixel arrived without an offset word |

## Verification
The assertions watch the handshake on every cycle. They check that `ofs_ready` never rises during a table write or without a pixel, that a missing offset raises `underrun` one cycle later, and that every output pixel, with its markers, traces back exactly three cycles to an accepted input. They also check that a table write cycle never yields an output and that reset clears the output flags. Only the bench scenarios can show the actual mapped values: correct subtraction, the zero floor where wrapping would give a very different table entry, bypass using the raw sample, and table contents surviving a reset. These need a reference table and a model of the arithmetic.

// File: rtl/fpn_pkg.sv
package fpn_pkg;
    localparam int PIX_W = 10;
    localparam int OUT_W = 8;

    typedef struct packed {
        logic             vld;
        logic             sof;
        logic             eol;
        logic             byp;
        logic [PIX_W-1:0] pix;
        logic [PIX_W-1:0] ofs;
    } fetch_st_t;

    typedef struct packed {
        logic             vld;
        logic             sof;
        logic             eol;
        logic [PIX_W-1:0] idx;
    } corr_st_t;

    typedef struct packed {
        logic vld;
        logic sof;
        logic eol;
    } side_st_t;

    typedef struct packed {
        fetch_st_t fetch;
        corr_st_t  corr;
        side_st_t  side;
        logic      urun;
    } pipe_st_t;
endpackage

// File: rtl/fpn_sub_clamp.sv
module fpn_sub_clamp #(
    parameter int W = 10,
    parameter bit FLOOR_AT_ZERO = 1'b1
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] ofs,
    input  logic         bypass,
    output logic [W-1:0] idx
);
    localparam int DW = W + 1;

    logic [DW-1:0] diff;
    logic [W-1:0]  corrected;

    always_comb diff = {1'b0, raw} - {1'b0, ofs};

    generate
        if (FLOOR_AT_ZERO) begin : g_floor
            // borrow bit set means the offset exceeded the sample
            always_comb corrected = diff[DW-1] ? '0 : diff[W-1:0];
        end else begin : g_wrap
            always_comb corrected = diff[W-1:0];
        end
    endgenerate

    always_comb idx = bypass ? raw : corrected;
endmodule

// File: rtl/fpn_lut_ram.sv
module fpn_lut_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata_q <= mem[raddr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/fpn_gamma_pipe.sv
module fpn_gamma_pipe
    import fpn_pkg::*;
#(
    parameter int PW = PIX_W,
    parameter int OW = OUT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          corr_en,
    input  logic          pix_valid,
    input  logic [PW-1:0] pix_data,
    input  logic          pix_sof,
    input  logic          pix_eol,
    input  logic          ofs_valid,
    input  logic [PW-1:0] ofs_data,
    output logic          ofs_ready,
    input  logic          lut_we,
    input  logic [PW-1:0] lut_addr,
    input  logic [OW-1:0] lut_wdata,
    output logic          out_valid,
    output logic [OW-1:0] out_data,
    output logic          out_sof,
    output logic          out_eol,
    output logic          underrun
);
    pipe_st_t      st_d, st_q;
    logic          take;
    logic [PW-1:0] corr_idx;
    logic [OW-1:0] lut_rdata;

    fpn_sub_clamp #(.W(PW), .FLOOR_AT_ZERO(1'b1)) sub_i (
        .raw    (st_q.fetch.pix),
        .ofs    (st_q.fetch.ofs),
        .bypass (st_q.fetch.byp),
        .idx    (corr_idx)
    );

    fpn_lut_ram #(.AW(PW), .DW(OW)) lut_i (
        .clk   (clk),
        .we    (lut_we),
        .waddr (lut_addr),
        .wdata (lut_wdata),
        .re    (st_q.corr.vld),
        .raddr (st_q.corr.idx),
        .rdata (lut_rdata)
    );

    always_comb begin
        take = pix_valid && ofs_valid && !lut_we;
        st_d = st_q;

        st_d.fetch.vld = take;
        st_d.fetch.sof = take && pix_sof;
        st_d.fetch.eol = take && pix_eol;
        st_d.fetch.byp = !corr_en;
        st_d.fetch.pix = pix_data;
        st_d.fetch.ofs = ofs_data;

        st_d.corr.vld  = st_q.fetch.vld;
        st_d.corr.sof  = st_q.fetch.sof;
        st_d.corr.eol  = st_q.fetch.eol;
        st_d.corr.idx  = corr_idx;

        st_d.side.vld  = st_q.corr.vld;
        st_d.side.sof  = st_q.corr.sof;
        st_d.side.eol  = st_q.corr.eol;

        st_d.urun      = pix_valid && !ofs_valid && !lut_we;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ofs_ready = pix_valid && !lut_we;
    assign out_valid = st_q.side.vld;
    assign out_sof   = st_q.side.sof;
    assign out_eol   = st_q.side.eol;
    assign out_data  = lut_rdata;
    assign underrun  = st_q.urun;
endmodule

// File: rtl/fpn_gamma_pipe_chk.sv
module fpn_gamma_pipe_chk (
    input logic clk,
    input logic rst,
    input logic pix_valid,
    input logic ofs_valid,
    input logic pix_sof,
    input logic pix_eol,
    input logic lut_we,
    input logic ofs_ready,
    input logic out_valid,
    input logic out_sof,
    input logic out_eol,
    input logic underrun
);
    // R4
    ready_blocked_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        lut_we |-> !ofs_ready);

    // R4
    ready_needs_pixel_chk: assert property (@(posedge clk) disable iff (rst)
        ofs_ready |-> pix_valid);

    // R5
    missing_offset_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !ofs_valid && !lut_we) |=> underrun);

    // R6
    output_traces_accept_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(pix_valid && ofs_valid && !lut_we, 3));

    // R7
    sof_alignment_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sof) |-> $past(pix_sof, 3));

    // R7
    eol_alignment_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_eol) |-> $past(pix_eol, 3));

    // R8
    write_cycle_no_output_chk: assert property (@(posedge clk) disable iff (rst)
        lut_we |-> ##3 !out_valid);

    // R9
    reset_clears_flags_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !underrun));
endmodule

bind fpn_gamma_pipe fpn_gamma_pipe_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .ofs_valid (ofs_valid),
    .pix_sof   (pix_sof),
    .pix_eol   (pix_eol),
    .lut_we    (lut_we),
    .ofs_ready (ofs_ready),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eol   (out_eol),
    .underrun  (underrun)
);

// File: tb/fpn_gamma_pipe_tb.sv
module fpn_gamma_pipe_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       corr_en = 1'b1;
    logic       pix_valid = 1'b0;
    logic [9:0] pix_data = '0;
    logic       pix_sof = 1'b0;
    logic       pix_eol = 1'b0;
    logic       ofs_valid = 1'b0;
    logic [9:0] ofs_data = '0;
    logic       ofs_ready;
    logic       lut_we = 1'b0;
    logic [9:0] lut_addr = '0;
    logic [7:0] lut_wdata = '0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_sof;
    logic       out_eol;
    logic       underrun;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpn_gamma_pipe dut_i (
        .clk(clk), .rst(rst), .corr_en(corr_en),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_sof(pix_sof), .pix_eol(pix_eol),
        .ofs_valid(ofs_valid), .ofs_data(ofs_data), .ofs_ready(ofs_ready),
        .lut_we(lut_we), .lut_addr(lut_addr), .lut_wdata(lut_wdata),
        .out_valid(out_valid), .out_data(out_data),
        .out_sof(out_sof), .out_eol(out_eol), .underrun(underrun)
    );

    typedef struct {
        bit    v;
        bit    sof;
        bit    eol;
        int    d;
        string tag;
    } exp_t;

    exp_t  exp_q[$];
    bit    urun_q[$];
    int    lut_m [1024];
    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic prime();
        exp_t e;
        e.v = 0; e.sof = 0; e.eol = 0; e.d = 0; e.tag = "R9";
        exp_q.delete();
        urun_q.delete();
        repeat (3) exp_q.push_back(e);
        urun_q.push_back(1'b0);
    endtask

    task automatic step(input bit pv, input bit ov, input bit ce, input int p,
                        input int o, input bit sf, input bit el,
                        input bit we, input int wa, input int wd);
        exp_t e, cur;
        bit   u;
        int   idx;
        cur = exp_q.pop_front();
        u   = urun_q.pop_front();
        check(out_valid == cur.v, (cur.tag == "R8") ? "R8" : "R6", "out_valid",
              int'(out_valid), int'(cur.v));
        if (cur.v) begin
            check(int'(out_data) == cur.d, cur.tag, "out_data", int'(out_data), cur.d);
            check(out_sof == cur.sof && out_eol == cur.eol, "R7", "sof/eol",
                  int'({out_sof, out_eol}), int'({cur.sof, cur.eol}));
        end
        check(underrun == u, "R5", "underrun", int'(underrun), int'(u));

        pix_valid = pv; ofs_valid = ov; corr_en = ce;
        pix_data = 10'(p); ofs_data = 10'(o);
        pix_sof = sf; pix_eol = el;
        lut_we = we; lut_addr = 10'(wa); lut_wdata = 8'(wd);
        #1;
        check(ofs_ready == (pv && !we), "R4", "ofs_ready", int'(ofs_ready), int'(pv && !we));

        e.v = pv && ov && !we;
        e.sof = e.v && sf; e.eol = e.v && el;
        if (!ce) begin
            idx = p; e.tag = "R3";
        end else if (p < o) begin
            idx = 0; e.tag = "R2";
        end else begin
            idx = p - o; e.tag = "R1";
        end
        e.d = lut_m[idx];
        if (pv && we) e.tag = "R8";
        exp_q.push_back(e);
        urun_q.push_back(pv && !ov && !we);
        if (we) lut_m[wa] = wd;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1; pix_valid = 0; lut_we = 0; ofs_valid = 0;
        @(posedge clk);
        @(negedge clk);
        check(!out_valid && !underrun, "R9", "flags after reset",
              int'({out_valid, underrun}), 0);
        rst = 1'b0;
        prime();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) lut_m[i] = 0;
        @(negedge clk);
        do_reset();

        // R8: fill table, a pixel presented during some writes is ignored
        for (int i = 0; i < 1024; i++)
            step((i % 5) == 0, 1, 1, 100, 3, 1, 0, 1, i, (i * i) >> 12);
        idle(4);

        // R1: normal correction stream with markers
        for (int i = 0; i < 40; i++) begin
            int p, o;
            p = 200 + int'($urandom_range(0, 800));
            o = int'($urandom_range(0, 190));
            step(1, 1, 1, p, o, i == 0, (i % 8) == 7, 0, 0, 0);
        end
        step(1, 1, 1, 1023, 0, 0, 0, 0, 0, 0);
        step(1, 1, 1, 512, 512, 0, 1, 0, 0, 0);
        idle(4);

        // R2: offset larger than sample floors at zero (wrap would hit table top)
        step(1, 1, 1, 5, 20, 1, 0, 0, 0, 0);
        step(1, 1, 1, 0, 1023, 0, 0, 0, 0, 0);
        step(1, 1, 1, 300, 301, 0, 1, 0, 0, 0);
        idle(4);

        // R3: bypass uses raw sample
        step(1, 1, 0, 700, 300, 1, 0, 0, 0, 0);
        step(1, 1, 0, 1023, 1023, 0, 0, 0, 0, 0);
        step(1, 1, 0, 10, 900, 0, 1, 0, 0, 0);
        idle(4);

        // R4 R5 R6: gaps, missing offsets, lone offsets
        step(1, 1, 1, 900, 100, 0, 0, 0, 0, 0);
        step(0, 1, 1, 800, 100, 0, 0, 0, 0, 0);
        step(1, 0, 1, 800, 100, 0, 0, 0, 0, 0);
        step(1, 0, 1, 600, 100, 1, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 1, 640, 40, 0, 1, 0, 0, 0);
        idle(4);

        // R9: rewrite entries, reset mid-stream, table retained
        step(0, 0, 1, 0, 0, 0, 0, 1, 100, 77);
        step(0, 0, 1, 0, 0, 0, 0, 1, 0, 201);
        idle(3);
        step(1, 1, 1, 600, 500, 1, 0, 0, 0, 0);
        step(1, 1, 1, 700, 500, 0, 0, 0, 0, 0);
        do_reset();
        step(1, 1, 1, 600, 500, 1, 0, 0, 0, 0);
        step(1, 1, 1, 3, 9, 0, 1, 0, 0, 0);
        idle(5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule